// File: doc/BRIEF.md
# Fibonacci Sequencer with Halt

This block produces the Fibonacci number F(N) for a small unsigned index N. A one-cycle start strobe latches the index, loads the first two sequence terms into a pair of value registers through a seed multiplexer, and clears a step counter. On each following clock, the value pair advances by one term of the recurrence F(i) = F(i-1) + F(i-2), where F(0) = 0 and F(1) = 1.

A comparator watches the step counter against the latched index. When the two match, it turns off the register enables, so the result stops on F(N) and holds there until the next start. The seed multiplexer starts every run from known terms, so the block needs no particular power-on contents. This is why N = 0 and N = 1 work like every other index.

Top module: `fib_halt_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `result` = 0 and `done` = 0.
- R2: A clock edge with `start` high reseeds the sequence. In the next cycle `result` = 0, which is F(0).
- R3: After the edge that samples `start`, and while `done` is low, the k-th later clock edge leaves `result` = F(k).
- R4: `done` first goes high in the cycle where `result` first equals F(N). It is low in every earlier cycle of the run.
- R5: Once `done` is high and `start` stays low, `result` and `done` do not change, even over 20 or more cycles.
- R6: For N = 0, `done` is high in the cycle right after the start edge, with `result` = 0. For N = 1, `done` rises one edge later, with `result` = 1.
- R7: A start strobe given during a run that has not finished abandons that run. The block begins again from F(0) with the newly latched index.
- R8: N = 15, the largest index, gives `result` = 610 exactly 15 edges after the start edge.
- R9: `n_in` is sampled only on a start edge. Changing it at any other time does not alter the final result or the cycle in which `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe: latch index and reseed |
| n_in | input | 4 | Unsigned Fibonacci index, 0 to 15 |
| result | output | 10 | Current sequence value; F(N) once finished |
| done | output | 1 | High while result holds F(N) |

## Verification
The bench sweeps every index from 0 to 15 and checks the result after each edge against a Fibonacci value it computes itself. This catches a comparator that is one step off, which would stop on F(N-1) or F(N+1) and raise `done` a cycle early or late. The bench holds the block for 25 cycles after completion, so it also catches a counter whose enables are never pulled low, which would let the result run past F(N). The indices 0 and 1 get their own attention because a wrong seed multiplexer produces the wrong value before any addition takes place. The bench also restarts the block in the middle of a run and changes `n_in` while a run is in progress, which exposes stale state and an index that is sampled when it should not be.

// File: rtl/fib_pkg.sv
package fib_pkg;
    localparam int IDX_W_DEF = 4;
    localparam int RES_W_DEF = 10;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_STEP = 2'd1,
        PH_DONE = 2'd2
    } fib_phase_e;

    localparam int SEED_LO = 0;
    localparam int SEED_HI = 1;
endpackage

// File: rtl/fib_step_ctrl.sv
module fib_step_ctrl
    import fib_pkg::*;
#(
    parameter int IDX_W = IDX_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IDX_W-1:0] n_in,
    output logic             step_en,
    output logic             done
);
    fib_phase_e       phase_q;
    logic [IDX_W-1:0] cnt_q;
    logic [IDX_W-1:0] tgt_q;
    logic [IDX_W-1:0] cnt_nxt;
    logic             hit_nxt;

    assign cnt_nxt = cnt_q + 1'b1;
    assign hit_nxt = (cnt_nxt == tgt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            tgt_q   <= '0;
        end else if (start) begin
            tgt_q   <= n_in;
            cnt_q   <= '0;
            phase_q <= (n_in == '0) ? PH_DONE : PH_STEP;
        end else if (phase_q == PH_STEP) begin
            cnt_q <= cnt_nxt;
            if (hit_nxt) phase_q <= PH_DONE;
        end
    end

    assign step_en = (phase_q == PH_STEP) && !start;
    assign done    = (phase_q == PH_DONE);

    // R4: while stepping the counter stays below the target
    p_cnt_below_r4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_STEP) |-> (cnt_q < tgt_q));

    // R9: the latched index only moves on a start edge
    p_idx_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(tgt_q));

    // R6: a zero index finishes at once
    p_zero_idx_r6: assert property (@(posedge clk) disable iff (rst)
        (start && n_in == '0) |=> done);
endmodule

// File: rtl/fib_pair_reg.sv
module fib_pair_reg
    import fib_pkg::*;
#(
    parameter int RES_W = RES_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             seed,
    input  logic             step_en,
    output logic [RES_W-1:0] result
);
    logic [RES_W-1:0] lo_q, hi_q;
    logic [RES_W-1:0] lo_d, hi_d;
    logic             load;

    // seed multiplexer in front of the recurrence adder
    always_comb begin
        if (seed) begin
            lo_d = RES_W'(SEED_LO);
            hi_d = RES_W'(SEED_HI);
        end else begin
            lo_d = hi_q;
            hi_d = lo_q + hi_q;
        end
    end

    assign load = seed || step_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= RES_W'(SEED_LO);
            hi_q <= RES_W'(SEED_HI);
        end else if (load) begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end

    assign result = lo_q;

    // R3: a step shifts the upper term down into the result
    p_step_shift_r3: assert property (@(posedge clk) disable iff (rst)
        (step_en && !seed) |=> (lo_q == $past(hi_q)));

    // R2: seeding restarts the sequence at zero
    p_seed_zero_r2: assert property (@(posedge clk) disable iff (rst)
        seed |=> (lo_q == '0 && hi_q == RES_W'(1)));
endmodule

// File: rtl/fib_halt_seq.sv
module fib_halt_seq
    import fib_pkg::*;
#(
    parameter int IDX_W = IDX_W_DEF,
    parameter int RES_W = RES_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IDX_W-1:0] n_in,
    output logic [RES_W-1:0] result,
    output logic             done
);
    logic step_en;

    fib_step_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .n_in    (n_in),
        .step_en (step_en),
        .done    (done)
    );

    fib_pair_reg #(.RES_W(RES_W)) u_pair (
        .clk     (clk),
        .rst     (rst),
        .seed    (start),
        .step_en (step_en),
        .result  (result)
    );

    // R1: reset clears outputs
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (result == '0 && !done));

    // R5: finished value holds until restarted
    p_hold_value_r5: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(result)));

    // R4: a nonzero index is never done right after start
    p_not_early_r4: assert property (@(posedge clk) disable iff (rst)
        (start && n_in != '0) |=> !done);

    // R7: start always reseeds the result
    p_restart_r7: assert property (@(posedge clk) disable iff (rst)
        start |=> (result == '0));
endmodule

// File: tb/sim_fib_halt_seq.sv
`timescale 1ns/1ps
module sim_fib_halt_seq;
    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [3:0] n_in;
    logic [9:0] result;
    logic       done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fib_halt_seq u0 (
        .clk(clk), .rst(rst), .start(start),
        .n_in(n_in), .result(result), .done(done)
    );

    function automatic int fib(input int k);
        int a = 0;
        int b = 1;
        for (int i = 0; i < k; i++) begin
            int t = a + b;
            a = b;
            b = t;
        end
        return a;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic kick(input int n);
        start = 1'b1;
        n_in  = 4'(n);
        tick();
        start = 1'b0;
    endtask

    task automatic run_index(input int n);
        kick(n);
        chk(result == 10'd0, "R2 seed F0", result, 0);
        chk(done == (n == 0), "R6/R4 done after start", done, n == 0);
        for (int k = 1; k <= n; k++) begin
            n_in = 4'(15 - n); // R9: index changes mid-run must be ignored
            tick();
            chk(result == 10'(fib(k)), "R3 step value", result, fib(k));
            chk(done == (k == n), "R4 done timing", done, k == n);
        end
        for (int h = 0; h < 25; h++) begin
            n_in = 4'(h);
            tick();
            if (result != 10'(fib(n)) || !done)
                chk(1'b0, "R5 hold", result, fib(n));
        end
        chk(result == 10'(fib(n)) && done, "R5 hold end", result, fib(n));
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; n_in = '0;
        tick(); tick();
        chk(result == 10'd0, "R1 reset result", result, 0);
        chk(done == 1'b0, "R1 reset done", done, 0);
        rst = 1'b0;
        tick();
        chk(done == 1'b0, "R1 idle not done", done, 0);

        for (int n = 0; n < 16; n++) run_index(n);

        // R6: small indices explicitly
        kick(1);
        chk(!done && result == 0, "R6 N=1 first", result, 0);
        tick();
        chk(done && result == 1, "R6 N=1 done", result, 1);

        // R8: top index
        kick(15);
        for (int k = 0; k < 14; k++) tick();
        chk(!done, "R8 not yet", done, 0);
        tick();
        chk(done && result == 10'd610, "R8 F15", result, 610);

        // R7: restart mid-run with a new index
        kick(12);
        for (int k = 0; k < 5; k++) tick();
        chk(result == 10'(fib(5)), "R7 midway", result, fib(5));
        kick(7);
        chk(result == 0 && !done, "R7 reseeded", result, 0);
        for (int k = 1; k <= 7; k++) tick();
        chk(done && result == 10'(fib(7)), "R7 new result", result, fib(7));

        // R1: reset mid-run
        kick(9);
        tick(); tick();
        rst = 1'b1;
        tick();
        chk(result == 0 && !done, "R1 reset mid-run", result, 0);
        rst = 1'b0;
        tick();

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule